// File: doc/BRIEF.md
# Variant-Aware Display Control and Card Status Register

This block holds one display-control word and one card-status word behind a simple register port. A board-variant code is taken from a 12-bit field (bits 27:16) of a system-identification input. That code decides four things: which display bits a write may change, what the display word holds after reset, whether writes also drive a 2-bit pixel-format select output, and where the write-protect input shows up in the card-status word.

Software writes the display word at word address 0 and reads both words combinationally. The display word is at address 0 and the card-status word is at address 1. The card-status word is read-only. It samples two external inputs, card detect and write protect, once per clock. The system-ID input is taken to be static. It may only change while reset is held.

Top module: `disp_ctl_top`

## Requirements
- R1: After reset the display word reads 0x00001F00 (value 0x1F in bits 13:8, meaning a VGA panel) on every variant except 0x190, where it reads 0x00000000.
- R2: On variants 0x100 and 0x140 a write to address 0 leaves bits 13:8 unchanged. Every other bit takes the written data.
- R3: On variant 0x100 every write to address 0 copies data bits 1:0 to `pixFmtSel` one cycle after the write edge. The output holds that value until the next such write and is 0 after reset.
- R4: On every variant other than 0x100, `pixFmtSel` stays 0 whatever is written.
- R5: On variants 0x178 and 0x182 a write to address 0 leaves bit 7 unchanged. Every other bit takes the written data.
- R6: On variant 0x190 the display word always reads zero, and writes to it have no effect.
- R7: Bit 0 of the card-status word (address 1) equals the `cardDetect` level sampled at the previous clock edge.
- R8: The sampled `writeProtect` level appears at card-status bit 2 on variants 0x100 and 0x140, and at bit 1 on all other variants. All other card-status bits read 0.
- R9: On any variant code not listed above, writes to the display word are ignored and it keeps reading 0x00001F00.
- R10: Reads of any address other than 0 and 1 return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| sysId | input | 32 | System identification word; bits 27:16 give the variant code |
| wrEn | input | 1 | Write strobe |
| addr | input | 4 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| cardDetect | input | 1 | Card-present level |
| writeProtect | input | 1 | Card write-protect level |
| pixFmtSel | output | 2 | Pixel-format select output |

## Verification
The variant code is static, so no single reset sequence can reach more than one write mask, reset value or status layout. Each scenario therefore loads a new system-ID word while reset is held and then releases reset. The preserved-field cases are hardest to see, because the preserved bits would look correct if the writes had simply copied the reset value. The stimulus writes all-ones and then all-zeros, so a preserved bit that was lost shows up as flipped in one of the two reads.

// File: rtl/disp_ctl_pkg.sv
package disp_ctl_pkg;
  localparam int DATA_W   = 32;
  localparam int ID_LSB   = 16;
  localparam int ID_W     = 12;
  localparam int MUX_W    = 2;
  localparam int RO_LSB   = 8;
  localparam int RO_W     = 6;
  localparam int KEEP_BIT = 7;
  localparam logic [RO_W-1:0] PANEL_CODE = 6'h1F;

  localparam logic [ID_W-1:0] VAR_A = 12'h100;
  localparam logic [ID_W-1:0] VAR_B = 12'h140;
  localparam logic [ID_W-1:0] VAR_C = 12'h178;
  localparam logic [ID_W-1:0] VAR_D = 12'h182;
  localparam logic [ID_W-1:0] VAR_E = 12'h190;

  typedef struct packed {
    logic              dispWr;
    logic [DATA_W-1:0] keepMask;
    logic              muxWr;
    logic              raz;
    logic              wpHigh;
    logic [DATA_W-1:0] rstVal;
  } strobe_t;
endpackage

// File: rtl/disp_ctl_ctrl.sv
module disp_ctl_ctrl
  import disp_ctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] DISP_ADDR = '0
) (
  input  logic [ID_W-1:0]   variant,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);
  localparam logic [DATA_W-1:0] RO_MASK   = DATA_W'(((1 << RO_W) - 1) << RO_LSB);
  localparam logic [DATA_W-1:0] BIT7_MASK = DATA_W'(1) << KEEP_BIT;
  localparam logic [DATA_W-1:0] PANEL_RST = DATA_W'(PANEL_CODE) << RO_LSB;

  logic hit;
  assign hit = wrEn && (addr == DISP_ADDR);

  always_comb begin
    stb.dispWr   = 1'b0;
    stb.keepMask = '1;
    stb.muxWr    = 1'b0;
    stb.raz      = 1'b0;
    stb.wpHigh   = 1'b0;
    stb.rstVal   = PANEL_RST;
    unique case (variant)
      VAR_A: begin
        stb.dispWr = hit; stb.keepMask = RO_MASK; stb.muxWr = hit; stb.wpHigh = 1'b1;
      end
      VAR_B: begin
        stb.dispWr = hit; stb.keepMask = RO_MASK; stb.wpHigh = 1'b1;
      end
      VAR_C, VAR_D: begin
        stb.dispWr = hit; stb.keepMask = BIT7_MASK;
      end
      VAR_E: begin
        stb.raz = 1'b1; stb.rstVal = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/disp_ctl_dp.sv
module disp_ctl_dp
  import disp_ctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] DISP_ADDR = '0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cardDetect,
  input  logic              writeProtect,
  output logic [DATA_W-1:0] rdData,
  output logic [MUX_W-1:0]  pixFmtSel
);
  logic [DATA_W-1:0] dispReg;
  logic [2:0]        cardStat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispReg   <= stb.rstVal;
      pixFmtSel <= '0;
      cardStat  <= '0;
    end else begin
      if (stb.dispWr) dispReg <= (dispReg & stb.keepMask) | (wrData & ~stb.keepMask);
      if (stb.muxWr)  pixFmtSel <= wrData[MUX_W-1:0];
      cardStat <= stb.wpHigh ? {writeProtect, 1'b0, cardDetect}
                             : {1'b0, writeProtect, cardDetect};
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == DISP_ADDR)      rdData = stb.raz ? '0 : dispReg;
    else if (addr == STAT_ADDR) rdData = DATA_W'(cardStat);
  end

  assert_raz_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.raz |-> dispReg == '0);
  assert_ro_field_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && stb.keepMask[RO_LSB] && stb.keepMask[RO_LSB+RO_W-1])
      |=> $stable(dispReg[RO_LSB+RO_W-1:RO_LSB]));
  assert_keep_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && stb.keepMask[KEEP_BIT]) |=> $stable(dispReg[KEEP_BIT]));
  assert_mux_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !stb.muxWr) |=> $stable(pixFmtSel));
  assert_card_bit_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |=> cardStat[0] == $past(cardDetect));
endmodule

// File: rtl/disp_ctl_top.sv
module disp_ctl_top
  import disp_ctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       sysId,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              cardDetect,
  input  logic              writeProtect,
  output logic [1:0]        pixFmtSel
);
  strobe_t stb;
  logic [ID_W-1:0] variant;
  assign variant = sysId[ID_LSB +: ID_W];

  disp_ctl_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .variant(variant), .wrEn(wrEn), .addr(addr), .stb(stb));

  disp_ctl_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wrData(wrData),
    .cardDetect(cardDetect), .writeProtect(writeProtect),
    .rdData(rdData), .pixFmtSel(pixFmtSel));

  assert_mux_other_R4: assert property (@(posedge clk) disable iff (!rstN)
    (variant != VAR_A) |-> pixFmtSel == '0);
endmodule

// File: tb/disp_ctl_top_test.sv
module disp_ctl_top_test;
  logic clk = 0, rstN = 0, wrEn = 0, cardDetect = 0, writeProtect = 0;
  logic [31:0] sysId = 0, wrData = 0, rdData;
  logic [3:0] addr = 0;
  logic [1:0] pixFmtSel;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  disp_ctl_top uut (.clk(clk), .rstN(rstN), .sysId(sysId), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .cardDetect(cardDetect),
    .writeProtect(writeProtect), .pixFmtSel(pixFmtSel));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic boot(logic [11:0] v);
    @(negedge clk); rstN = 0; sysId = {4'h0, v, 16'h1234};
    repeat (2) @(negedge clk); rstN = 1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(logic [3:0] a, string tag, logic [31:0] exp);
    @(negedge clk); addr = a; #1; check(tag, rdData, exp);
  endtask

  task automatic t_varA();
    boot(12'h100);
    rd(0, "R1 reset A", 32'h1F00); check("R3 reset mux", {30'd0, pixFmtSel}, 0);
    wr(0, 32'hFFFF_FFFF);
    rd(0, "R2 ones A", 32'hFFFF_DFFF); check("R3 mux 3", {30'd0, pixFmtSel}, 3);
    wr(0, 32'h0000_0002);
    rd(0, "R2 zeros A", 32'h0000_1F02); check("R3 mux 2", {30'd0, pixFmtSel}, 2);
    wr(5, 32'h0000_0001);
    check("R3 mux hold", {30'd0, pixFmtSel}, 2);
    rd(0, "R10 no effect", 32'h0000_1F02);
    rd(5, "R10 unmapped", 0);
  endtask

  task automatic t_varB();
    boot(12'h140);
    wr(0, 32'hFFFF_FFFF);
    rd(0, "R2 ones B", 32'hFFFF_DFFF);
    check("R4 no mux B", {30'd0, pixFmtSel}, 0);
  endtask

  task automatic t_varCD(logic [11:0] v);
    boot(v);
    rd(0, "R1 reset CD", 32'h1F00);
    wr(0, 32'hFFFF_FFFF);
    rd(0, "R5 ones", 32'hFFFF_FF7F);
    wr(0, 32'h0000_0000);
    rd(0, "R5 zeros", 0);
    check("R4 no mux CD", {30'd0, pixFmtSel}, 0);
  endtask

  task automatic t_varE();
    boot(12'h190);
    rd(0, "R1 reset E", 0);
    wr(0, 32'hFFFF_FFFF);
    rd(0, "R6 raz", 0);
    check("R4 no mux E", {30'd0, pixFmtSel}, 0);
  endtask

  task automatic t_unknown();
    boot(12'h0AB);
    wr(0, 32'h1234_5678);
    rd(0, "R9 ignored", 32'h1F00);
  endtask

  task automatic card(logic [11:0] v, logic cd, logic wp, logic [31:0] exp, string tag);
    boot(v);
    @(negedge clk); cardDetect = cd; writeProtect = wp; addr = 1;
    @(posedge clk); #1; check(tag, rdData, exp);
  endtask

  initial begin
    t_varA();
    t_varB();
    t_varCD(12'h178);
    t_varCD(12'h182);
    t_varE();
    t_unknown();
    card(12'h100, 1, 0, 32'h1, "R7 cd only");
    card(12'h100, 0, 1, 32'h4, "R8 wp bit2 A");
    card(12'h140, 1, 1, 32'h5, "R8 wp bit2 B");
    card(12'h178, 0, 1, 32'h2, "R8 wp bit1 C");
    card(12'h190, 1, 1, 32'h3, "R8 wp bit1 E");
    @(negedge clk); cardDetect = 0; writeProtect = 0;
    @(posedge clk); #1; check("R7 cleared", rdData, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule